// File: doc/BRIEF.md
# Flash Write Status Bit Generator

This block builds the word a NOR-style flash array returns when the host polls it while an embedded program or erase is running. A controller supplies the current operation, a busy flag, a flag saying whether the polled address lies in the sector whose erase is suspended, the bit being programmed and the array word at that address. From these the block forms the word on the data bus and a ready/busy line. Array storage, algorithm timing and command decode are handled elsewhere.

Three bit positions carry status. The polling bit at position 7 reports the complement of the bit being written, or a fixed value during erase and suspend. Two toggle flip-flops drive positions 6 and 2. Each inverts when the read strobe falls, so successive status reads alternate. Which of the two toggles, and whether either toggles at all, depends on the operation and on the sector flag. Both clear when a new operation is presented, so the first read of an operation returns 0 on both toggle bits.

All other bit positions, and the whole word whenever no status applies, come straight from the array input. Both outputs are registered.

Top module: `fsb_status_gen`

## Requirements
- R1: While `rst` is high, `dq_o` is all zeros and `rdy_o` is 1. Both toggle states are 0 after reset.
- R2: With `busy_i`=1 and `op_i`=1 (program), bit 7 of `dq_o` equals the inverse of `prog_bit_i`, and `rdy_o` is 0.
- R3: The toggle bit at position 6 inverts on every falling edge of `rd_i` while `busy_i`=1 and `op_i` is 1, 2 or 4. Both toggle bits read 0 on the first read after `op_i` takes a new value.
- R4: During a busy program (`op_i` 1 or 4), bit 2 of `dq_o` holds its value from read to read.
- R5: With `busy_i`=1 and `op_i`=2 (erase), bit 7 is 0, bits 6 and 2 both invert on each read, and `rdy_o` is 0.
- R6: With `op_i`=3 (erase suspended) and `sect_i`=1, bits 7 and 6 read 1, bit 2 inverts on each read, and `rdy_o` is 1.
- R7: With `op_i`=3 and `sect_i`=0, `dq_o` equals `array_i` and `rdy_o` is 1. Such reads leave both toggle states unchanged, as seen on the next read from the suspended sector.
- R8: With `busy_i`=1 and `op_i`=4 (program inside erase suspend), the status matches a normal program: bit 7 inverted data, bit 6 toggling, bit 2 steady, `rdy_o` 0.
- R9: When `busy_i`=0 and `op_i` is not 3, `dq_o` equals `array_i` and `rdy_o` is 1. Reads in this state leave the toggle states unchanged.
- R10: `dq_o` and `rdy_o` reflect the inputs one clock after they are applied. They stay constant while the inputs are held and `rd_i` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 3 | Operation: 0 idle, 1 program, 2 erase, 3 erase suspended, 4 program during suspend |
| busy_i | input | 1 | Embedded algorithm running |
| sect_i | input | 1 | Polled address lies in the suspended sector |
| prog_bit_i | input | 1 | Data bit being programmed at position 7 |
| array_i | input | DATA_W | Array word at the polled address |
| rd_i | input | 1 | Read strobe, high during a read |
| dq_o | output | DATA_W | Registered read data or status word |
| rdy_o | output | 1 | Registered ready (1) / busy (0) |

## Verification
Every output is one register away from the inputs, so a changed input shows on `dq_o` and `rdy_o` one clock later. A toggle advances in the clock after the strobe falls and shows on the next read. The bench sets the inputs, waits two clock edges, raises the strobe and samples twice more while it is held. It lowers the strobe and waits several edges before the next read. The checks therefore never fall in a cycle where a toggle or input change is still travelling through the registers. An extra case changes `array_i` and samples after exactly one edge, to pin down the single-register latency.

// File: rtl/fsb_pkg.sv
package fsb_pkg;
  typedef enum logic [2:0] {
    OP_IDLE      = 3'd0,
    OP_PROG      = 3'd1,
    OP_ERASE     = 3'd2,
    OP_SUSP      = 3'd3,
    OP_SUSP_PROG = 3'd4
  } fsb_op_e;

  localparam int unsigned N_TGL = 2;
  localparam int unsigned TGL_POLL6 = 0;
  localparam int unsigned TGL_SECT2 = 1;
endpackage

// File: rtl/fsb_edge_det.sv
module fsb_edge_det
  import fsb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       strobe_i,
  input  logic [2:0] op_i,
  output logic       fall_o,
  output logic       new_op_o
);
  logic       strobe_q;
  logic [2:0] op_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      op_q     <= OP_IDLE;
    end else begin
      strobe_q <= strobe_i;
      op_q     <= op_i;
    end
  end

  assign fall_o   = strobe_q & ~strobe_i;
  assign new_op_o = (op_q != op_i);
endmodule

// File: rtl/fsb_toggle_ff.sv
module fsb_toggle_ff (
  input  logic clk,
  input  logic rst,
  input  logic clr_i,
  input  logic adv_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (rst || clr_i) q_o <= 1'b0;
    else if (adv_i)   q_o <= ~q_o;
  end
endmodule

// File: rtl/fsb_status_mux.sv
module fsb_status_mux
  import fsb_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned POS_POLL = 7,
  parameter int unsigned POS_TGL  = 6,
  parameter int unsigned POS_SECT = 2
) (
  input  logic [2:0]        op_i,
  input  logic              busy_i,
  input  logic              sect_i,
  input  logic              prog_bit_i,
  input  logic [DATA_W-1:0] array_i,
  input  logic              tgl_poll_i,
  input  logic              tgl_sect_i,
  output logic [DATA_W-1:0] word_o,
  output logic              rdy_o
);
  fsb_op_e op;
  logic    in_prog, in_erase, in_susp;

  always_comb begin
    op       = fsb_op_e'(op_i);
    in_prog  = busy_i && (op == OP_PROG || op == OP_SUSP_PROG);
    in_erase = busy_i && (op == OP_ERASE);
    in_susp  = (op == OP_SUSP) && sect_i;

    word_o = array_i;
    rdy_o  = 1'b1;
    if (in_prog) begin
      word_o[POS_POLL] = ~prog_bit_i;
      word_o[POS_TGL]  = tgl_poll_i;
      word_o[POS_SECT] = tgl_sect_i;
      rdy_o            = 1'b0;
    end else if (in_erase) begin
      word_o[POS_POLL] = 1'b0;
      word_o[POS_TGL]  = tgl_poll_i;
      word_o[POS_SECT] = tgl_sect_i;
      rdy_o            = 1'b0;
    end else if (in_susp) begin
      word_o[POS_POLL] = 1'b1;
      word_o[POS_TGL]  = 1'b1;
      word_o[POS_SECT] = tgl_sect_i;
    end
  end
endmodule

// File: rtl/fsb_status_gen.sv
module fsb_status_gen
  import fsb_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned POS_POLL = 7,
  parameter int unsigned POS_TGL  = 6,
  parameter int unsigned POS_SECT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        op_i,
  input  logic              busy_i,
  input  logic              sect_i,
  input  logic              prog_bit_i,
  input  logic [DATA_W-1:0] array_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              rdy_o
);
  logic              rd_fall, new_op;
  logic [N_TGL-1:0]  tgl_adv, tgl_q;
  logic [DATA_W-1:0] word_nxt;
  logic              rdy_nxt;
  fsb_op_e           op;

  fsb_edge_det u_edge (
    .clk      (clk),
    .rst      (rst),
    .strobe_i (rd_i),
    .op_i     (op_i),
    .fall_o   (rd_fall),
    .new_op_o (new_op)
  );

  always_comb begin
    op = fsb_op_e'(op_i);
    tgl_adv[TGL_POLL6] = rd_fall && busy_i &&
                         (op == OP_PROG || op == OP_ERASE || op == OP_SUSP_PROG);
    tgl_adv[TGL_SECT2] = rd_fall && ((busy_i && op == OP_ERASE) ||
                                     (op == OP_SUSP && sect_i));
  end

  for (genvar g = 0; g < N_TGL; g++) begin : g_tgl
    fsb_toggle_ff u_tgl (
      .clk   (clk),
      .rst   (rst),
      .clr_i (new_op),
      .adv_i (tgl_adv[g]),
      .q_o   (tgl_q[g])
    );
  end

  fsb_status_mux #(
    .DATA_W   (DATA_W),
    .POS_POLL (POS_POLL),
    .POS_TGL  (POS_TGL),
    .POS_SECT (POS_SECT)
  ) u_mux (
    .op_i       (op_i),
    .busy_i     (busy_i),
    .sect_i     (sect_i),
    .prog_bit_i (prog_bit_i),
    .array_i    (array_i),
    .tgl_poll_i (tgl_q[TGL_POLL6]),
    .tgl_sect_i (tgl_q[TGL_SECT2]),
    .word_o     (word_nxt),
    .rdy_o      (rdy_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_o  <= '0;
      rdy_o <= 1'b1;
    end else begin
      dq_o  <= word_nxt;
      rdy_o <= rdy_nxt;
    end
  end
endmodule

// File: rtl/fsb_status_gen_chk.sv
module fsb_status_gen_chk #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned POS_POLL = 7,
  parameter int unsigned POS_TGL  = 6,
  parameter int unsigned POS_SECT = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        op_i,
  input logic              busy_i,
  input logic              sect_i,
  input logic              prog_bit_i,
  input logic [DATA_W-1:0] array_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] dq_o,
  input logic              rdy_o
);
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (dq_o == '0) && rdy_o);

  assert_prog_poll_R2: assert property (@(posedge clk) disable iff (rst)
    (busy_i && op_i == 3'd1) |=> (dq_o[POS_POLL] == ~$past(prog_bit_i)) && !rdy_o);

  assert_erase_poll_R5: assert property (@(posedge clk) disable iff (rst)
    (busy_i && op_i == 3'd2) |=> !dq_o[POS_POLL] && !rdy_o);

  assert_susp_sector_R6: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'd3 && sect_i) |=> dq_o[POS_POLL] && dq_o[POS_TGL] && rdy_o);

  assert_susp_other_R7: assert property (@(posedge clk) disable iff (rst)
    (op_i == 3'd3 && !sect_i) |=> (dq_o == $past(array_i)) && rdy_o);

  assert_idle_pass_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy_i && op_i != 3'd3) |=> (dq_o == $past(array_i)) && rdy_o);

  assert_hold_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd3 && rd_i && $past(rd_i) && $stable(op_i) &&
     $past(op_i, 2) == op_i && $stable(busy_i) && $stable(sect_i) &&
     $stable(prog_bit_i) && $stable(array_i))
    |=> $stable(dq_o) && $stable(rdy_o));
endmodule

bind fsb_status_gen fsb_status_gen_chk #(
  .DATA_W   (DATA_W),
  .POS_POLL (POS_POLL),
  .POS_TGL  (POS_TGL),
  .POS_SECT (POS_SECT)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .op_i       (op_i),
  .busy_i     (busy_i),
  .sect_i     (sect_i),
  .prog_bit_i (prog_bit_i),
  .array_i    (array_i),
  .rd_i       (rd_i),
  .dq_o       (dq_o),
  .rdy_o      (rdy_o)
);

// File: tb/fsb_status_gen_tb.sv
module fsb_status_gen_tb_top;
  localparam int unsigned DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    op_i = 3'd0;
  logic          busy_i = 1'b0;
  logic          sect_i = 1'b0;
  logic          prog_bit_i = 1'b0;
  logic [DW-1:0] array_i = '0;
  logic          rd_i = 1'b0;
  logic [DW-1:0] dq_o;
  logic          rdy_o;

  int checks = 0;
  int failures = 0;
  logic e6 = 1'b0, e2 = 1'b0;
  logic [2:0] cur_op = 3'd0;

  always #2 clk = ~clk;

  fsb_status_gen dut_i (
    .clk(clk), .rst(rst), .op_i(op_i), .busy_i(busy_i), .sect_i(sect_i),
    .prog_bit_i(prog_bit_i), .array_i(array_i), .rd_i(rd_i),
    .dq_o(dq_o), .rdy_o(rdy_o)
  );

  task automatic check(input string req, input logic [DW:0] act, input logic [DW:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic is_prog();
    return busy_i && (op_i == 3'd1 || op_i == 3'd4);
  endfunction

  function automatic logic [DW:0] model();
    logic [DW-1:0] w = array_i;
    logic r = 1'b1;
    if (is_prog()) begin
      w[7] = ~prog_bit_i; w[6] = e6; w[2] = e2; r = 1'b0;
    end else if (busy_i && op_i == 3'd2) begin
      w[7] = 1'b0; w[6] = e6; w[2] = e2; r = 1'b0;
    end else if (op_i == 3'd3 && sect_i) begin
      w[7] = 1'b1; w[6] = 1'b1; w[2] = e2;
    end
    return {r, w};
  endfunction

  function automatic string mode_tag();
    if (busy_i && op_i == 3'd1) return "R2";
    if (busy_i && op_i == 3'd4) return "R8";
    if (busy_i && op_i == 3'd2) return "R5";
    if (op_i == 3'd3) return sect_i ? "R6" : "R7";
    return "R9";
  endfunction

  task automatic set_in(input logic [2:0] op, input logic b, input logic s,
                        input logic pb, input logic [DW-1:0] arr);
    @(negedge clk);
    op_i = op; busy_i = b; sect_i = s; prog_bit_i = pb; array_i = arr;
    if (op != cur_op) begin e6 = 1'b0; e2 = 1'b0; cur_op = op; end
    repeat (2) @(negedge clk);
  endtask

  task automatic do_read();
    logic [DW:0] first;
    rd_i = 1'b1;
    repeat (2) @(negedge clk);
    first = {rdy_o, dq_o};
    check(mode_tag(), first, model());
    if (busy_i && (op_i == 3'd1 || op_i == 3'd2 || op_i == 3'd4))
      check("R3", {{DW{1'b0}}, dq_o[6]}, {{DW{1'b0}}, e6});
    if (is_prog())
      check("R4", {{DW{1'b0}}, dq_o[2]}, {{DW{1'b0}}, e2});
    @(negedge clk);
    check("R10", {rdy_o, dq_o}, first);
    rd_i = 1'b0;
    if (busy_i && (op_i == 3'd1 || op_i == 3'd2 || op_i == 3'd4)) e6 = ~e6;
    if ((busy_i && op_i == 3'd2) || (op_i == 3'd3 && sect_i)) e2 = ~e2;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    array_i = 16'hFFFF;
    repeat (3) @(negedge clk);
    check("R1", {rdy_o, dq_o}, {1'b1, {DW{1'b0}}});
    rst = 1'b0;
    @(negedge clk);

    // R10: single clock of latency in pass-through
    array_i = 16'h3C5A;
    @(negedge clk);
    check("R10", {rdy_o, dq_o}, {1'b1, 16'h3C5A});

    // exhaustive sweep of operation x busy x sector x programmed bit
    for (int op = 0; op < 5; op++)
      for (int b = 0; b < 2; b++)
        for (int s = 0; s < 2; s++)
          for (int pb = 0; pb < 2; pb++) begin
            set_in(3'(op), 1'(b), 1'(s), 1'(pb),
                   16'hA55A ^ 16'((op * 8 + b * 4 + s * 2 + pb) * 16'h0111));
            do_read();
            do_read();
            do_read();
          end

    // R7: non-sector reads in suspend must not advance the sector toggle
    set_in(3'd0, 1'b0, 1'b0, 1'b0, 16'h0000);
    set_in(3'd3, 1'b0, 1'b1, 1'b0, 16'h0F0F);
    do_read();
    set_in(3'd3, 1'b0, 1'b0, 1'b0, 16'h1234);
    do_read();
    do_read();
    set_in(3'd3, 1'b0, 1'b1, 1'b0, 16'h0F0F);
    check("R7", {{DW{1'b0}}, e2}, {{DW{1'b0}}, 1'b1});
    do_read();

    // R1: reset in the middle of an erase clears the toggles
    set_in(3'd2, 1'b1, 1'b0, 1'b0, 16'h00FF);
    do_read();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1", {rdy_o, dq_o}, {1'b1, {DW{1'b0}}});
    rst = 1'b0;
    e6 = 1'b0; e2 = 1'b0;
    repeat (2) @(negedge clk);
    do_read();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule